// File: doc/BRIEF.md
# Coherent-read ADC result register

This block holds the latest 10-bit converter result and presents it to a processor bus as two byte-wide read-only registers, a low byte and a high byte. A one-cycle `sample_valid_i` strobe together with `sample_i` loads a new result. The 10-bit value is stored exactly as delivered. A two's-complement result from a differential channel is therefore kept bit for bit.

The `left_adj_i` bit chooses how the result is placed across the 16-bit pair. When it is clear, the result is right-justified. When it is set, the result is left-justified. The placement is applied on the read path, so changing the bit re-places the stored value on the next read. No new load is needed.

Reading the low byte freezes the pair until the high byte is read. This gives software a coherent two-byte result. Results that complete during the freeze are discarded, and a sticky `overrun_o` flag reports the loss. Software that needs only 8 bits of a left-justified result may read just the high byte. That access never leaves the pair frozen.

Top module: `adc_result_reg`

## Requirements
- R1: After reset, both bytes read 0x00, the pair is not frozen, and `overrun_o` is 0.
- R2: With `left_adj_i`=0, the high byte (`rd_hi_sel_i`=1) reads {6'b0, result[9:8]} and the low byte (`rd_hi_sel_i`=0) reads result[7:0].
- R3: With `left_adj_i`=1, the high byte reads result[9:2] and the low byte reads {result[1:0], 6'b0}.
- R4: Changing `left_adj_i` changes the placement of the already stored result on the next read, without a new strobe.
- R5: When the pair is not frozen, a strobe loads `sample_i`, and the new value is readable from the next cycle.
- R6: A low-byte read (`rd_en_i`=1, `rd_hi_sel_i`=0) freezes the pair. A strobe in the same cycle as that read, or in any later cycle before a high-byte read, is discarded.
- R7: A high-byte read (`rd_en_i`=1, `rd_hi_sel_i`=1) always leaves the pair unfrozen, including when no low-byte read came before it. Strobes after it load normally.
- R8: A strobe in the same cycle as a high-byte read on a frozen pair loads the new sample. The read in that cycle returns the old byte, and the pair is unfrozen afterwards.
- R9: A discarded strobe sets `overrun_o` from the next cycle. It stays set until a high-byte read, and it reads 0 in the cycle after that read.
- R10: The result is stored without conversion. The two's-complement patterns 0x3FF (-1) and 0x200 (-512) read back with their raw bits in both layouts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 10 | Converter result |
| sample_valid_i | input | 1 | Conversion-complete strobe |
| left_adj_i | input | 1 | 1 = left-justified layout, 0 = right-justified |
| rd_en_i | input | 1 | Read strobe |
| rd_hi_sel_i | input | 1 | Byte select: 1 = high byte, 0 = low byte |
| rd_data_o | output | 8 | Selected byte, combinational from the stored result |
| overrun_o | output | 1 | Sticky flag: a result was discarded while frozen |

## Verification
The conversion-complete strobe can fall in the same cycle as either byte read, and these collisions are the cases that decide coherency. The bench drives a strobe in the same cycle as a low-byte read and checks three things: that read returns the old byte, the high byte still matches it afterwards, and `overrun_o` rises. It also drives a strobe in the same cycle as a high-byte read on a frozen pair. There it checks that the read returns the old high byte, the next low and high reads return the new sample, and `overrun_o` stays low.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
  localparam int unsigned RES_W_DEF  = 10;
  localparam int unsigned BYTE_W_DEF = 8;
  typedef enum logic {BYTE_LO = 1'b0, BYTE_HI = 1'b1} byte_sel_e;
endpackage

// File: rtl/adc_res_lock.sv
module adc_res_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lo_rd_i,
  input  logic hi_rd_i,
  input  logic sample_valid_i,
  output logic load_o,
  output logic drop_o,
  output logic locked_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      locked_q <= 1'b0;
    else if (hi_rd_i) locked_q <= 1'b0;
    else if (lo_rd_i) locked_q <= 1'b1;
  end

  // a high read releases before the load; a low read blocks in its own cycle
  always_comb begin
    load_o = sample_valid_i && !lo_rd_i && (!locked_q || hi_rd_i);
    drop_o = sample_valid_i && !load_o;
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/adc_res_store.sv
module adc_res_store #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [RES_W-1:0] sample_i,
  output logic [RES_W-1:0] data_o
);
  logic [RES_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_q <= '0;
    else if (load_i) data_q <= sample_i;
  end

  assign data_o = data_q;
endmodule

// File: rtl/adc_res_align.sv
module adc_res_align #(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [RES_W-1:0]  data_i,
  input  logic              left_adj_i,
  input  logic              sel_hi_i,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int unsigned WORD_W = 2 * BYTE_W;
  localparam int unsigned PAD_W  = WORD_W - RES_W;

  logic [WORD_W-1:0] word_r, word_l, word;

  generate
    if (PAD_W == 0) begin : g_full
      assign word_r = data_i;
      assign word_l = data_i;
    end else begin : g_pad
      assign word_r = {{PAD_W{1'b0}}, data_i};
      assign word_l = {data_i, {PAD_W{1'b0}}};
    end
  endgenerate

  assign word   = left_adj_i ? word_l : word_r;
  assign byte_o = sel_hi_i ? word[WORD_W-1 -: BYTE_W] : word[BYTE_W-1:0];
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg
  import adc_res_pkg::*;
#(
  parameter int unsigned RES_W  = RES_W_DEF,
  parameter int unsigned BYTE_W = BYTE_W_DEF,
  parameter bit          OVR_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RES_W-1:0]  sample_i,
  input  logic              sample_valid_i,
  input  logic              left_adj_i,
  input  logic              rd_en_i,
  input  logic              rd_hi_sel_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              overrun_o
);
  logic             lo_rd, hi_rd, load, drop, locked;
  logic [RES_W-1:0] res_q;

  assign lo_rd = rd_en_i && (byte_sel_e'(rd_hi_sel_i) == BYTE_LO);
  assign hi_rd = rd_en_i && (byte_sel_e'(rd_hi_sel_i) == BYTE_HI);

  adc_res_lock u_lock (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .lo_rd_i        (lo_rd),
    .hi_rd_i        (hi_rd),
    .sample_valid_i (sample_valid_i),
    .load_o         (load),
    .drop_o         (drop),
    .locked_o       (locked)
  );

  adc_res_store #(.RES_W(RES_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .sample_i (sample_i),
    .data_o   (res_q)
  );

  adc_res_align #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_align (
    .data_i     (res_q),
    .left_adj_i (left_adj_i),
    .sel_hi_i   (rd_hi_sel_i),
    .byte_o     (rd_data_o)
  );

  generate
    if (OVR_EN) begin : g_ovr
      logic ovr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    ovr_q <= 1'b0;
        else if (drop)  ovr_q <= 1'b1;
        else if (hi_rd) ovr_q <= 1'b0;
      end
      assign overrun_o = ovr_q;
    end else begin : g_no_ovr
      assign overrun_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/adc_result_reg_chk.sv
module adc_result_reg_chk #(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [RES_W-1:0]  sample_i,
  input logic              sample_valid_i,
  input logic              left_adj_i,
  input logic              rd_en_i,
  input logic              rd_hi_sel_i,
  input logic [BYTE_W-1:0] rd_data_o,
  input logic              overrun_o,
  input logic              locked,
  input logic [RES_W-1:0]  res_q
);
  // R2
  right_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!left_adj_i && rd_hi_sel_i) |-> rd_data_o == BYTE_W'(res_q >> BYTE_W));
  // R3
  left_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_adj_i && rd_hi_sel_i) |-> rd_data_o == res_q[RES_W-1 -: BYTE_W]);
  // R5
  load_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && !locked && !(rd_en_i && !rd_hi_sel_i)) |=> res_q == $past(sample_i));
  // R6
  frozen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((locked && !(rd_en_i && rd_hi_sel_i)) || (rd_en_i && !rd_hi_sel_i)) |=> $stable(res_q));
  // R7
  hi_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_hi_sel_i) |=> !locked);
  // R8
  release_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && locked && rd_en_i && rd_hi_sel_i) |=> (res_q == $past(sample_i) && !locked));
  // R9
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && locked && !(rd_en_i && rd_hi_sel_i)) |=> overrun_o);
endmodule

bind adc_result_reg adc_result_reg_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_i       (sample_i),
  .sample_valid_i (sample_valid_i),
  .left_adj_i     (left_adj_i),
  .rd_en_i        (rd_en_i),
  .rd_hi_sel_i    (rd_hi_sel_i),
  .rd_data_o      (rd_data_o),
  .overrun_o      (overrun_o),
  .locked         (locked),
  .res_q          (res_q)
);

// File: tb/adc_result_reg_tb.sv
module adc_result_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] sample = '0;
  logic       valid = 1'b0, adj = 1'b0, rd_en = 1'b0, rd_hi = 1'b0;
  logic [7:0] rd_data;
  logic       ovr;
  int         compared = 0, mismatched = 0, cycles = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #10 clk = ~clk;

  adc_result_reg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .sample_valid_i(valid),
    .left_adj_i(adj), .rd_en_i(rd_en), .rd_hi_sel_i(rd_hi),
    .rd_data_o(rd_data), .overrun_o(ovr)
  );

  function automatic logic [7:0] exp_byte(logic [9:0] s, logic left, logic hi);
    if (left) return hi ? s[9:2] : {s[1:0], 6'b0};
    return hi ? {6'b0, s[9:8]} : s[7:0];
  endfunction

  // one-cycle operation: drive at negedge, idle at the next negedge
  task automatic step(logic v, logic [9:0] s, logic rd, logic hi, logic [7:0] exp, string tag);
    @(negedge clk);
    valid = v; sample = s; rd_en = rd; rd_hi = hi;
    if (rd) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    @(negedge clk);
    valid = 1'b0; rd_en = 1'b0;
  endtask

  task automatic rd_byte(logic [9:0] s, logic hi, string tag);
    step(1'b0, '0, 1'b1, hi, exp_byte(s, adj, hi), tag);
  endtask

  task automatic load(logic [9:0] s);
    step(1'b1, s, 1'b0, 1'b0, 8'h00, "");
  endtask

  task automatic chk_ovr(logic e, string tag);
    #5;
    compared++;
    if (ovr !== e) begin
      mismatched++;
      $display("FAIL %s overrun_o: got %0b expected %0b", tag, ovr, e);
    end
  endtask

  // monitor: compare every read byte against the scoreboard
  initial begin
    forever begin
      @(negedge clk); #5;
      if (rd_en) begin
        if (exp_q.size() == 0) begin
          mismatched++;
          $display("FAIL unexpected read: got %02h expected none", rd_data);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          compared++;
          if (rd_data !== e) begin
            mismatched++;
            $display("FAIL %s read: got %02h expected %02h", t, rd_data, e);
          end
        end
      end
    end
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        mismatched++;
        $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    chk_ovr(1'b0, "R1");
    rd_byte(10'h000, 1'b0, "R1");
    rd_byte(10'h000, 1'b1, "R1");
    // R5 / R2 load and right-justified read
    load(10'h2A5);
    rd_byte(10'h2A5, 1'b0, "R2");
    rd_byte(10'h2A5, 1'b1, "R2");
    // R4 / R3 flip layout without a new load
    adj = 1'b1;
    rd_byte(10'h2A5, 1'b0, "R4");
    rd_byte(10'h2A5, 1'b1, "R3");
    adj = 1'b0;
    // R6 strobe after low read is dropped
    rd_byte(10'h2A5, 1'b0, "R6");
    load(10'h155);
    chk_ovr(1'b1, "R9");
    rd_byte(10'h2A5, 1'b1, "R6");
    chk_ovr(1'b0, "R9");
    rd_byte(10'h2A5, 1'b0, "R6");
    rd_byte(10'h2A5, 1'b1, "R6");
    // R6 strobe in the same cycle as the low read
    step(1'b1, 10'h0F0, 1'b1, 1'b0, exp_byte(10'h2A5, 1'b0, 1'b0), "R6");
    chk_ovr(1'b1, "R9");
    rd_byte(10'h2A5, 1'b1, "R6");
    chk_ovr(1'b0, "R9");
    // R7 high-only read leaves pair free
    rd_byte(10'h2A5, 1'b1, "R7");
    load(10'h3FF);
    chk_ovr(1'b0, "R7");
    rd_byte(10'h3FF, 1'b0, "R7");
    rd_byte(10'h3FF, 1'b1, "R10");
    // R8 strobe coincides with releasing high read
    rd_byte(10'h3FF, 1'b0, "R8");
    step(1'b1, 10'h1C3, 1'b1, 1'b1, exp_byte(10'h3FF, 1'b0, 1'b1), "R8");
    chk_ovr(1'b0, "R8");
    rd_byte(10'h1C3, 1'b0, "R8");
    rd_byte(10'h1C3, 1'b1, "R8");
    // R10 raw two's complement -512 in both layouts
    load(10'h200);
    rd_byte(10'h200, 1'b0, "R10");
    rd_byte(10'h200, 1'b1, "R10");
    adj = 1'b1;
    rd_byte(10'h200, 1'b0, "R10");
    rd_byte(10'h200, 1'b1, "R10");
    adj = 1'b0;
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule